// File: doc/BRIEF.md
# Fixed-Page Call/Return Stack Pointer

This block keeps the stack pointer of a small instruction sequencer that supports subroutine CALL and RETURN. The pointer is 16 bits wide. Its upper byte is tied to all ones, so every stack access falls inside the top 256-word page of the shared memory. Only the lower byte moves. It counts down on a call (push) and up on a return (pop). For each push or pop the block gives the memory address and a read or write strobe, so an external memory can store or fetch the return address.

A sequencer start can reload the pointer to its empty value (all ones). Whether it does depends on a configuration bit, the auto-reload enable, which comes out of reset set. When software clears that bit, a stopped sequence can be restarted with its call stack still in place. The host can also write the lower byte directly. A push that would wrap the page is refused and flagged as overflow. A pop from an empty stack is refused and flagged as underflow. In both cases the pointer does not move and no memory strobe is given.

Top module: `seq_stack_ptr`

## Requirements
- R1: After reset the pointer reads 0xFFFF, the auto-reload enable reads 1, and both error flags read 0.
- R2: Bits 15:8 of the pointer and of the memory address always read 0xFF, and a host write cannot change them.
- R3: A push with lower byte not 0x00 asserts the write strobe, drives the memory address with the pointer minus one, and then leaves the pointer decremented. A pop with lower byte not 0xFF asserts the read strobe, drives the current pointer, and then leaves the pointer incremented. With no operation the memory address equals the pointer and both strobes are 0.
- R4: A push while the lower byte is 0x00 leaves the pointer unchanged and gives no write strobe. The overflow flag is 1 in the following cycle only. Starting from 0xFFFF, exactly 255 pushes succeed.
- R5: A pop while the lower byte is 0xFF leaves the pointer unchanged and gives no read strobe. The underflow flag is 1 in the following cycle only.
- R6: A start while the auto-reload enable is 1 sets the pointer to 0xFFFF.
- R7: A start while the auto-reload enable is 0 leaves the pointer unchanged.
- R8: A host pointer write loads bits 7:0 of the write data into the lower byte, unless a push or pop happens in the same cycle. In that case the push or pop takes effect and the write is dropped.
- R9: Priority runs from start, to push, to pop, to host pointer write. The lower-ranked inputs of a cycle are ignored, including their strobes and flags.
- R10: A configuration write loads the auto-reload enable, shown on auto_en_o from the next cycle. A start in the same cycle still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Sequencer start strobe |
| push_i | input | 1 | CALL: push a return address |
| pop_i | input | 1 | RETURN: pop a return address |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_auto_i | input | 1 | New auto-reload enable value |
| ptr_wr_i | input | 1 | Host pointer write strobe |
| ptr_wdata_i | input | 16 | Host pointer write data, only bits 7:0 are used |
| sp_o | output | 16 | Current stack pointer |
| auto_en_o | output | 1 | Auto-reload enable |
| mem_addr_o | output | 16 | Stack memory address for this cycle |
| mem_we_o | output | 1 | Stack memory write strobe (push) |
| mem_re_o | output | 1 | Stack memory read strobe (pop) |
| ovf_o | output | 1 | Overflow pulse, one cycle after a refused push |
| unf_o | output | 1 | Underflow pulse, one cycle after a refused pop |

## Verification
A wrong lower byte appears on sp_o one cycle after the faulty update. It also appears on mem_addr_o in the same cycle as the next push or pop, so a return address would be stored or fetched at the wrong slot. An error at the page boundary appears either as a wrapped pointer with a strobe where a refusal was due, or as a missing flag pulse in the next cycle. A wrong auto-reload bit only shows at the next start: the pointer is either lost or kept against the setting. For this reason the bench starts the sequencer with both settings on a stack that is not empty.

// File: rtl/seq_stack_ptr.sv
module seq_stack_ptr #(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_auto_i,
  input  logic              ptr_wr_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              auto_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int HI_W = ADDR_W - PTR_W;
  localparam logic [HI_W-1:0] PAGE = '1;

  logic [PTR_W-1:0] low_q;
  logic             auto_q, ovf_q, unf_q;

  wire at_floor = (low_q == '0);
  wire at_top   = &low_q;
  wire do_push  = !start_i && push_i;
  wire do_pop   = !start_i && !push_i && pop_i;
  wire do_wr    = !start_i && !push_i && !pop_i && ptr_wr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '1;
      auto_q <= 1'b1;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      ovf_q <= do_push && at_floor;
      unf_q <= do_pop && at_top;
      if (cfg_wr_i) auto_q <= cfg_auto_i;
      if (start_i) begin
        if (auto_q) low_q <= '1;
      end else if (do_push) begin
        if (!at_floor) low_q <= low_q - 1'b1;
      end else if (do_pop) begin
        if (!at_top) low_q <= low_q + 1'b1;
      end else if (do_wr) begin
        low_q <= ptr_wdata_i[PTR_W-1:0];
      end
    end
  end

  assign sp_o       = {PAGE, low_q};
  assign auto_en_o  = auto_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;
  assign mem_we_o   = do_push && !at_floor;
  assign mem_re_o   = do_pop && !at_top;
  assign mem_addr_o = {PAGE, do_push ? low_q - 1'b1 : low_q};

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o) |=> (sp_o == $past(sp_o) - 1'b1)); // R3
  AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o) |=> (sp_o == $past(sp_o) + 1'b1)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && push_i && sp_o[PTR_W-1:0] == '0) |=> (ovf_o && $stable(sp_o))); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !push_i && pop_i && &sp_o[PTR_W-1:0]) |=> (unf_o && $stable(sp_o))); // R5
  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && auto_en_o) |=> (&sp_o)); // R6
  AST_START_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !auto_en_o) |=> $stable(sp_o)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R9
  AST_PAGE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || mem_re_o) |-> (mem_addr_o[ADDR_W-1:PTR_W] == sp_o[ADDR_W-1:PTR_W])); // R2
endmodule

// File: tb/seq_stack_ptr_tb_top.sv
module seq_stack_ptr_tb_top;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, push_i = 0, pop_i = 0, cfg_wr_i = 0, cfg_auto_i = 0, ptr_wr_i = 0;
  logic [15:0] ptr_wdata_i = 0;
  logic [15:0] sp_o, mem_addr_o;
  logic auto_en_o, mem_we_o, mem_re_o, ovf_o, unf_o;

  int checks = 0, errors = 0;
  logic [7:0] m_low;
  logic m_auto;

  always #5 clk = ~clk;

  seq_stack_ptr dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .push_i(push_i), .pop_i(pop_i),
    .cfg_wr_i(cfg_wr_i), .cfg_auto_i(cfg_auto_i), .ptr_wr_i(ptr_wr_i),
    .ptr_wdata_i(ptr_wdata_i), .sp_o(sp_o), .auto_en_o(auto_en_o),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .ovf_o(ovf_o), .unf_o(unf_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_mem(logic [7:0] low, logic st, logic pu, logic po);
    if (!st && pu && low != 8'h00) return {1'b1, 8'hFF, low - 8'd1};
    if (!st && !pu && po && low != 8'hFF) return {1'b1, 8'hFF, low};
    if (!st && pu) return {1'b0, 8'hFF, low - 8'd1};
    return {1'b0, 8'hFF, low};
  endfunction

  function automatic logic [7:0] exp_next(logic [7:0] low, logic au, logic st, logic pu,
                                         logic po, logic wr, logic [7:0] wd);
    if (st) return au ? 8'hFF : low;
    if (pu) return (low == 8'h00) ? low : low - 8'd1;
    if (po) return (low == 8'hFF) ? low : low + 8'd1;
    if (wr) return wd;
    return low;
  endfunction

  task automatic step(string req, logic st, logic pu, logic po, logic cw, logic ca,
                      logic wr, logic [15:0] wd);
    logic [16:0] em;
    logic eo, eu;
    start_i = st; push_i = pu; pop_i = po; cfg_wr_i = cw; cfg_auto_i = ca;
    ptr_wr_i = wr; ptr_wdata_i = wd;
    #1;
    em = exp_mem(m_low, st, pu, po);
    chk({req, " R3 addr"}, mem_addr_o, em[15:0]);
    chk({req, " R9 we"}, mem_we_o, !st && pu && m_low != 8'h00);
    chk({req, " R9 re"}, mem_re_o, !st && !pu && po && m_low != 8'hFF);
    eo = !st && pu && m_low == 8'h00;
    eu = !st && !pu && po && m_low == 8'hFF;
    m_low = exp_next(m_low, m_auto, st, pu, po, wr, wd[7:0]);
    if (cw) m_auto = ca;
    @(posedge clk); @(negedge clk);
    start_i = 0; push_i = 0; pop_i = 0; cfg_wr_i = 0; ptr_wr_i = 0;
    chk({req, " R2 sp"}, sp_o, {8'hFF, m_low});
    chk({req, " R4 ovf"}, ovf_o, eo);
    chk({req, " R5 unf"}, unf_o, eu);
    chk({req, " R10 auto"}, auto_en_o, m_auto);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1553);
    m_low = 8'hFF; m_auto = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 sp", sp_o, 16'hFFFF);
    chk("R1 auto", auto_en_o, 1);
    chk("R1 flags", {ovf_o, unf_o}, 0);
    step("R5 empty pop", 0, 0, 1, 0, 0, 0, 0);
    step("R3 call1", 0, 1, 0, 0, 0, 0, 0);
    step("R3 call2", 0, 1, 0, 0, 0, 0, 0);
    step("R3 call3", 0, 1, 0, 0, 0, 0, 0);
    step("R3 ret1", 0, 0, 1, 0, 0, 0, 0);
    step("R8 wr", 0, 0, 0, 0, 0, 1, 16'h1234);
    step("R2 upper ignored", 0, 0, 0, 0, 0, 1, 16'h00A0);
    step("R8 push beats wr", 0, 1, 0, 0, 0, 1, 16'h0055);
    step("R8 pop beats wr", 0, 0, 1, 0, 0, 1, 16'h0011);
    step("R9 push beats pop", 0, 1, 1, 0, 0, 0, 0);
    step("R9 start beats push", 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 255; i++) step("R4 fill", 0, 1, 0, 0, 0, 0, 0);
    chk("R4 full", sp_o, 16'hFF00);
    step("R4 overflow", 0, 1, 0, 0, 0, 0, 0);
    step("R4 pulse ends", 0, 0, 0, 0, 0, 0, 0);
    step("R10 clear auto, start same cycle", 1, 0, 0, 1, 0, 0, 0);
    chk("R6 reload", sp_o, 16'hFFFF);
    step("R3 call", 0, 1, 0, 0, 0, 0, 0);
    step("R3 call", 0, 1, 0, 0, 0, 0, 0);
    step("R7 start keeps", 1, 0, 0, 0, 0, 0, 0);
    chk("R7 kept", sp_o, 16'hFFFD);
    step("R10 set auto", 0, 0, 0, 1, 1, 0, 0);
    step("R6 start reload", 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step("R3 R8 random", r[7:5] == 0, r[0], r[1], r[4:2] == 0, r[3],
           r[2], 16'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule